// File: doc/BRIEF.md
# Write-Update Snooping Coherence Controller

This block is the coherence engine of one write-back cache that shares a snooping bus with other caches. Copies of a line are kept consistent by broadcasting every word written to a shared line, so that other holders patch their copies. Copies are never thrown away to keep coherence. The state a line moves to after a fill or a broadcast is picked from a wired-OR "shared" response that any other cache holding the block raises. The lines are direct mapped, and the line data array is part of the block.

The processor side accepts single-word reads and writes. A miss fetches the whole line through a block-read transaction. Before that, the victim is written back when this cache owns its data. The bus side watches the transactions of the other caches: block reads, which this cache answers by raising its shared output and, when it owns the line, by driving the line data, and word-update broadcasts, which patch its copy. Arbitration, memory and the wired-OR are outside the block. Its own bus commands and the snooped transactions are assumed never to overlap in time.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset every line is absent, `req_ready` is 1, `bus_cmd` is 0 (idle), `rsp_valid` is 0, and a snoop to any address sees `snp_shared` and `snp_supply` at 0.
- R2: A read miss issues `bus_cmd` 1 (block read) with the word offset of `bus_addr` zero. In the cycle after the `bus_done` cycle, `rsp_valid` is 1 and `rsp_rdata` is the requested word taken from lane `offset` of `bus_rdata` (lane k is bits k*DATA_W upward). The line becomes Shared-Clean if `bus_shared` was 1 with `bus_done`, and Valid-Exclusive otherwise.
- R3: A read hit raises `rsp_valid` with the stored word in the cycle after acceptance, and issues no bus command.
- R4: A write hit on a Valid-Exclusive or Dirty line issues no bus command, stores the word, leaves the line Dirty and responds in the next cycle.
- R5: A write hit on a Shared-Clean or Shared-Dirty line issues `bus_cmd` 2 (word update), with `bus_addr` equal to the word address and the word in lane 0 of `bus_wdata`. The line becomes Shared-Dirty if `bus_shared` was 1 with `bus_done`, and Dirty otherwise. `rsp_valid` follows one cycle after `bus_done`. Memory is never written by a write hit.
- R6: A write miss fetches the line as in R2. If `bus_shared` was 1, a word update as in R5 follows. Otherwise the word is stored, the line becomes Dirty with no further bus command, and the write responds.
- R7: On a miss whose victim is Dirty or Shared-Dirty, `bus_cmd` 3 (write-back) comes first, with the victim's line address and full line data, and the block read follows immediately. Clean victims are dropped with no bus command.
- R8: A snooped block read (`snp_upd` 0) that hits raises `snp_shared` in the same cycle. If the line is Dirty or Shared-Dirty, `snp_supply` is also 1 and `snp_rdata` carries the line. Dirty becomes Shared-Dirty, Valid-Exclusive becomes Shared-Clean, and the other states are kept.
- R9: A snooped word update (`snp_upd` 1) that hits raises `snp_shared`, never `snp_supply`, writes `snp_wdata` into the line and leaves the line Shared-Clean.
- R10: A snoop that misses raises neither output and changes no stored line.
- R11: While `snp_valid` is 1, `req_ready` is 0, so snooping takes precedence over the processor.
- R12: A bus command and its address stay unchanged until the cycle in which `bus_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Write word |
| req_ready | output | 1 | Request accepted at this edge when high |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read word, or the written word for writes |
| bus_cmd | output | 2 | 0 idle, 1 block read, 2 word update, 3 write-back |
| bus_addr | output | ADDR_W | Line address (read, write-back) or word address (update) |
| bus_wdata | output | WORDS*DATA_W | Line for write-back, word in lane 0 for update |
| bus_done | input | 1 | Current bus command completes this cycle |
| bus_shared | input | 1 | Wired-OR shared response, valid with bus_done |
| bus_rdata | input | WORDS*DATA_W | Line data for a block read, valid with bus_done |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_upd | input | 1 | 1 = word update, 0 = block read |
| snp_addr | input | ADDR_W | Snooped address |
| snp_wdata | input | DATA_W | Snooped update word |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache drives the snooped line's data |
| snp_rdata | output | WORDS*DATA_W | Supplied line data, zero when not supplying |

## Verification
The bench builds the controller with ADDR_W=8, DATA_W=16, LINES=4 and WORDS=4. That leaves four tag bits, so two addresses 16 words apart land on the same line and force evictions within a few requests. The whole 256-word memory fits in a bench array that takes write-backs and serves fills. Every line state is reached and then told apart at the ports: a write hit on it either broadcasts or stays silent, and a snooped read either gets data or does not. Write-backs are confirmed by re-reading the evicted words from memory.

// File: rtl/upd_coh_pkg.sv
package upd_coh_pkg;

   typedef enum logic [2:0] {
      LS_INV = 3'd0,
      LS_VE  = 3'd1,
      LS_SC  = 3'd2,
      LS_SD  = 3'd3,
      LS_D   = 3'd4
   } line_st_t;

   typedef enum logic [1:0] {
      BUS_NONE = 2'd0,
      BUS_RD   = 2'd1,
      BUS_UPD  = 2'd2,
      BUS_WB   = 2'd3
   } bus_cmd_t;

   typedef enum logic [1:0] {
      F_IDLE = 2'd0,
      F_WB   = 2'd1,
      F_FILL = 2'd2,
      F_UPD  = 2'd3
   } fsm_t;

   function automatic logic owns_data(line_st_t st);
      return (st == LS_D) || (st == LS_SD);
   endfunction

endpackage

// File: rtl/upd_coh_tags.sv
module upd_coh_tags
   import upd_coh_pkg::*;
#(
   parameter int LINES = 4,
   parameter int TAG_W = 4,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] a_idx,
   output logic [TAG_W-1:0] a_tag,
   output line_st_t         a_st,
   input  logic [IDX_W-1:0] b_idx,
   output logic [TAG_W-1:0] b_tag,
   output line_st_t         b_st,
   input  logic             p_we,
   input  logic [IDX_W-1:0] p_idx,
   input  logic [TAG_W-1:0] p_tag,
   input  line_st_t         p_st,
   input  logic             s_we,
   input  logic [IDX_W-1:0] s_idx,
   input  line_st_t         s_st
);

   logic [TAG_W-1:0] tag_arr [LINES];
   line_st_t         st_arr  [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [TAG_W-1:0] tag_q;
      line_st_t         st_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q  <= LS_INV;
            tag_q <= '0;
         end else if (s_we && s_idx == IDX_W'(g)) begin
            st_q <= s_st;
         end else if (p_we && p_idx == IDX_W'(g)) begin
            st_q  <= p_st;
            tag_q <= p_tag;
         end
      end

      assign tag_arr[g] = tag_q;
      assign st_arr[g]  = st_q;
   end

   assign a_tag = tag_arr[a_idx];
   assign a_st  = st_arr[a_idx];
   assign b_tag = tag_arr[b_idx];
   assign b_st  = st_arr[b_idx];

endmodule

// File: rtl/upd_coh_data.sv
module upd_coh_data #(
   parameter int LINES  = 4,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(LINES),
   localparam int OFF_W = $clog2(WORDS),
   localparam int BLK_W = WORDS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  a_idx,
   output logic [BLK_W-1:0]  a_blk,
   input  logic [IDX_W-1:0]  b_idx,
   output logic [BLK_W-1:0]  b_blk,
   input  logic              f_we,
   input  logic [IDX_W-1:0]  f_idx,
   input  logic [BLK_W-1:0]  f_blk,
   input  logic              w_we,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic [OFF_W-1:0]  w_off,
   input  logic [DATA_W-1:0] w_data,
   input  logic              s_we,
   input  logic [IDX_W-1:0]  s_idx,
   input  logic [OFF_W-1:0]  s_off,
   input  logic [DATA_W-1:0] s_data
);

   logic [BLK_W-1:0] blk_arr [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [BLK_W-1:0] blk_q;
      logic [BLK_W-1:0] blk_d;

      always_comb begin
         blk_d = blk_q;
         if (f_we && f_idx == IDX_W'(g))
            blk_d = f_blk;
         if (w_we && w_idx == IDX_W'(g))
            blk_d[w_off*DATA_W +: DATA_W] = w_data;
         if (s_we && s_idx == IDX_W'(g))
            blk_d[s_off*DATA_W +: DATA_W] = s_data;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) blk_q <= '0;
         else        blk_q <= blk_d;
      end

      assign blk_arr[g] = blk_q;
   end

   assign a_blk = blk_arr[a_idx];
   assign b_blk = blk_arr[b_idx];

endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
   import upd_coh_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int LINES  = 4,
   parameter int WORDS  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic                    req_write,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [DATA_W-1:0]       req_wdata,
   output logic                    req_ready,
   output logic                    rsp_valid,
   output logic [DATA_W-1:0]       rsp_rdata,
   output logic [1:0]              bus_cmd,
   output logic [ADDR_W-1:0]       bus_addr,
   output logic [WORDS*DATA_W-1:0] bus_wdata,
   input  logic                    bus_done,
   input  logic                    bus_shared,
   input  logic [WORDS*DATA_W-1:0] bus_rdata,
   input  logic                    snp_valid,
   input  logic                    snp_upd,
   input  logic [ADDR_W-1:0]       snp_addr,
   input  logic [DATA_W-1:0]       snp_wdata,
   output logic                    snp_shared,
   output logic                    snp_supply,
   output logic [WORDS*DATA_W-1:0] snp_rdata
);

   localparam int OFF_W = $clog2(WORDS);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
   localparam int BLK_W = WORDS * DATA_W;

   if (WORDS < 2 || (1 << OFF_W) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end

   // address fields
   logic [OFF_W-1:0] r_off, q_off, s_off;
   logic [IDX_W-1:0] r_idx, q_idx, s_idx;
   logic [TAG_W-1:0] r_tag, q_tag, s_tag;
   logic [ADDR_W-1:0] q_addr;
   logic [DATA_W-1:0] q_wdata;
   logic              q_write;

   assign {r_tag, r_idx, r_off} = req_addr;
   assign {q_tag, q_idx, q_off} = q_addr;
   assign {s_tag, s_idx, s_off} = snp_addr;

   fsm_t fsm_q, fsm_d;

   // storage ports
   logic [IDX_W-1:0] a_idx;
   logic [TAG_W-1:0] a_tag, b_tag;
   line_st_t         a_st, b_st;
   logic [BLK_W-1:0] a_blk, b_blk;
   logic             t_we, f_we, w_we, sn_t_we, sn_d_we;
   logic [IDX_W-1:0] t_idx;
   logic [TAG_W-1:0] t_tag;
   line_st_t         t_st, sn_st;
   logic [OFF_W-1:0] w_off;
   logic [DATA_W-1:0] w_data;
   logic             rsp_v_d;
   logic [DATA_W-1:0] rsp_d;
   logic             capture;

   assign a_idx = (fsm_q == F_IDLE) ? r_idx : q_idx;

   upd_coh_tags #(.LINES(LINES), .TAG_W(TAG_W)) i_tags (
      .clk(clk), .rst_n(rst_n),
      .a_idx(a_idx), .a_tag(a_tag), .a_st(a_st),
      .b_idx(s_idx), .b_tag(b_tag), .b_st(b_st),
      .p_we(t_we), .p_idx(t_idx), .p_tag(t_tag), .p_st(t_st),
      .s_we(sn_t_we), .s_idx(s_idx), .s_st(sn_st)
   );

   upd_coh_data #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) i_data (
      .clk(clk), .rst_n(rst_n),
      .a_idx(a_idx), .a_blk(a_blk),
      .b_idx(s_idx), .b_blk(b_blk),
      .f_we(f_we), .f_idx(q_idx), .f_blk(bus_rdata),
      .w_we(w_we), .w_idx(t_idx), .w_off(w_off), .w_data(w_data),
      .s_we(sn_d_we), .s_idx(s_idx), .s_off(s_off), .s_data(snp_wdata)
   );

   // processor-side lookup (request address while idle, held address otherwise)
   logic a_hit;
   assign a_hit = (a_st != LS_INV) &&
                  (a_tag == ((fsm_q == F_IDLE) ? r_tag : q_tag));

   assign req_ready = (fsm_q == F_IDLE) && !snp_valid;

   always_comb begin
      fsm_d   = fsm_q;
      capture = 1'b0;
      t_we    = 1'b0;
      t_idx   = q_idx;
      t_tag   = q_tag;
      t_st    = LS_INV;
      f_we    = 1'b0;
      w_we    = 1'b0;
      w_off   = q_off;
      w_data  = q_wdata;
      rsp_v_d = 1'b0;
      rsp_d   = rsp_rdata;
      unique case (fsm_q)
         F_IDLE: begin
            if (req_valid && req_ready) begin
               capture = 1'b1;
               if (a_hit && !req_write) begin
                  rsp_v_d = 1'b1;
                  rsp_d   = a_blk[r_off*DATA_W +: DATA_W];
               end else if (a_hit && (a_st == LS_VE || a_st == LS_D)) begin
                  t_we    = 1'b1;
                  t_idx   = r_idx;
                  t_tag   = r_tag;
                  t_st    = LS_D;
                  w_we    = 1'b1;
                  w_off   = r_off;
                  w_data  = req_wdata;
                  rsp_v_d = 1'b1;
                  rsp_d   = req_wdata;
               end else if (a_hit) begin
                  fsm_d = F_UPD;
               end else if (owns_data(a_st)) begin
                  fsm_d = F_WB;
               end else begin
                  fsm_d = F_FILL;
               end
            end
         end
         F_WB: begin
            if (bus_done) begin
               t_we  = 1'b1;
               t_tag = a_tag;
               t_st  = LS_INV;
               fsm_d = F_FILL;
            end
         end
         F_FILL: begin
            if (bus_done) begin
               t_we  = 1'b1;
               f_we  = 1'b1;
               t_st  = bus_shared ? LS_SC : LS_VE;
               if (!q_write) begin
                  rsp_v_d = 1'b1;
                  rsp_d   = bus_rdata[q_off*DATA_W +: DATA_W];
                  fsm_d   = F_IDLE;
               end else if (bus_shared) begin
                  fsm_d = F_UPD;
               end else begin
                  t_st    = LS_D;
                  w_we    = 1'b1;
                  rsp_v_d = 1'b1;
                  rsp_d   = q_wdata;
                  fsm_d   = F_IDLE;
               end
            end
         end
         F_UPD: begin
            if (bus_done) begin
               t_we    = 1'b1;
               t_st    = bus_shared ? LS_SD : LS_D;
               w_we    = 1'b1;
               rsp_v_d = 1'b1;
               rsp_d   = q_wdata;
               fsm_d   = F_IDLE;
            end
         end
         default: fsm_d = F_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm_q     <= F_IDLE;
         q_addr    <= '0;
         q_wdata   <= '0;
         q_write   <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         fsm_q     <= fsm_d;
         rsp_valid <= rsp_v_d;
         rsp_rdata <= rsp_d;
         if (capture) begin
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
            q_write <= req_write;
         end
      end
   end

   // bus master outputs, held while the state waits for bus_done
   always_comb begin
      bus_cmd   = BUS_NONE;
      bus_addr  = '0;
      bus_wdata = '0;
      unique case (fsm_q)
         F_WB: begin
            bus_cmd   = BUS_WB;
            bus_addr  = {a_tag, q_idx, {OFF_W{1'b0}}};
            bus_wdata = a_blk;
         end
         F_FILL: begin
            bus_cmd  = BUS_RD;
            bus_addr = {q_tag, q_idx, {OFF_W{1'b0}}};
         end
         F_UPD: begin
            bus_cmd   = BUS_UPD;
            bus_addr  = q_addr;
            bus_wdata = {{(BLK_W-DATA_W){1'b0}}, q_wdata};
         end
         default: ;
      endcase
   end

   // snoop side
   logic s_hit;
   assign s_hit      = snp_valid && (b_st != LS_INV) && (b_tag == s_tag);
   assign snp_shared = s_hit;
   assign snp_supply = s_hit && !snp_upd && owns_data(b_st);
   assign snp_rdata  = snp_supply ? b_blk : '0;

   assign sn_t_we = s_hit && (snp_upd || b_st == LS_VE || b_st == LS_D);
   assign sn_st   = (!snp_upd && b_st == LS_D) ? LS_SD : LS_SC;
   assign sn_d_we = s_hit && snp_upd;

endmodule

// File: rtl/upd_coh_ctrl_chk.sv
module upd_coh_ctrl_chk
   import upd_coh_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [1:0]        bus_cmd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_done,
   input logic              snp_valid,
   input logic              snp_shared,
   input logic              snp_supply
);

   // R1: first cycle out of reset is quiet
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (bus_cmd == BUS_NONE && !rsp_valid && req_ready == !snp_valid));

   // R3: no bus command while accepting requests
   p_idle_no_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> bus_cmd == BUS_NONE);

   // R5: an update completes into a response
   p_upd_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == BUS_UPD && bus_done) |=> rsp_valid);

   // R7: write-back is followed by the block read
   p_wb_then_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == BUS_WB && bus_done) |=> bus_cmd == BUS_RD);

   // R8: supplying data implies asserting shared
   p_supply_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> snp_shared);

   // R11: snoop blocks the processor side
   p_snoop_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !req_ready);

   // R12: bus command and address hold until done
   p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd != BUS_NONE && !bus_done) |=>
         (bus_cmd == $past(bus_cmd) && bus_addr == $past(bus_addr)));

endmodule

bind upd_coh_ctrl upd_coh_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
   .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_done(bus_done),
   .snp_valid(snp_valid), .snp_shared(snp_shared), .snp_supply(snp_supply)
);

// File: tb/test_upd_coh_ctrl.sv
module test_upd_coh_ctrl;

   localparam int AW = 8;
   localparam int DW = 16;
   localparam int NL = 4;
   localparam int NW = 4;
   localparam int BW = NW * DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [1:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [BW-1:0] bus_wdata;
   logic          bus_done = 1'b0, bus_shared = 1'b0;
   logic [BW-1:0] bus_rdata = '0;
   logic          snp_valid = 1'b0, snp_upd = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic [DW-1:0] snp_wdata = '0;
   logic          snp_shared, snp_supply;
   logic [BW-1:0] snp_rdata;

   always #4 clk = ~clk;

   upd_coh_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .WORDS(NW)) i_upd_coh_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_done(bus_done), .bus_shared(bus_shared), .bus_rdata(bus_rdata),
      .snp_valid(snp_valid), .snp_upd(snp_upd), .snp_addr(snp_addr),
      .snp_wdata(snp_wdata), .snp_shared(snp_shared), .snp_supply(snp_supply),
      .snp_rdata(snp_rdata)
   );

   int n_tests = 0;
   int n_fail  = 0;
   logic [DW-1:0] mem [1 << AW];

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // ops: 0 processor read, 1 processor write, 2 snooped read, 3 snooped update
   typedef struct packed {
      logic [3:0]    req;
      logic [1:0]    op;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic          sh;
      logic [DW-1:0] exp_data;
      logic [3:0]    exp_mask;
      logic [AW-1:0] exp_wb;
      logic          exp_shared;
      logic          exp_supply;
   } vec_t;

   localparam int NV = 22;
   localparam logic [60:0] VECS [NV] = '{
      {4'd2,  2'd0, 8'h05, 16'h0000, 1'b0, 16'h1005, 4'b0010, 8'h00, 1'b0, 1'b0}, // R2 miss -> VE
      {4'd3,  2'd0, 8'h06, 16'h0000, 1'b0, 16'h1006, 4'b0000, 8'h00, 1'b0, 1'b0}, // R3 hit
      {4'd4,  2'd1, 8'h06, 16'hBEEF, 1'b0, 16'hBEEF, 4'b0000, 8'h00, 1'b0, 1'b0}, // R4 VE write
      {4'd4,  2'd0, 8'h06, 16'h0000, 1'b0, 16'hBEEF, 4'b0000, 8'h00, 1'b0, 1'b0}, // R4 word stored
      {4'd8,  2'd2, 8'h06, 16'h0000, 1'b0, 16'hBEEF, 4'b0000, 8'h00, 1'b1, 1'b1}, // R8 D supplies -> SD
      {4'd5,  2'd1, 8'h07, 16'h1234, 1'b1, 16'h1234, 4'b0100, 8'h00, 1'b0, 1'b0}, // R5 SD -> SD
      {4'd8,  2'd2, 8'h07, 16'h0000, 1'b0, 16'h1234, 4'b0000, 8'h00, 1'b1, 1'b1}, // R8 SD supplies
      {4'd5,  2'd1, 8'h05, 16'h5555, 1'b0, 16'h5555, 4'b0100, 8'h00, 1'b0, 1'b0}, // R5 SD -> D
      {4'd9,  2'd3, 8'h04, 16'h7777, 1'b0, 16'h0000, 4'b0000, 8'h00, 1'b1, 1'b0}, // R9 update -> SC
      {4'd9,  2'd0, 8'h04, 16'h0000, 1'b0, 16'h7777, 4'b0000, 8'h00, 1'b0, 1'b0}, // R9 word patched
      {4'd5,  2'd1, 8'h04, 16'h4444, 1'b0, 16'h4444, 4'b0100, 8'h00, 1'b0, 1'b0}, // R5 SC -> D
      {4'd7,  2'd0, 8'h15, 16'h0000, 1'b1, 16'h1015, 4'b1010, 8'h04, 1'b0, 1'b0}, // R7 D victim, R2 SC
      {4'd7,  2'd0, 8'h06, 16'h0000, 1'b0, 16'hBEEF, 4'b0010, 8'h00, 1'b0, 1'b0}, // R7 SC dropped
      {4'd10, 2'd2, 8'h26, 16'h0000, 1'b0, 16'h0000, 4'b0000, 8'h00, 1'b0, 1'b0}, // R10 read miss
      {4'd10, 2'd3, 8'h25, 16'h9999, 1'b0, 16'h0000, 4'b0000, 8'h00, 1'b0, 1'b0}, // R10 update miss
      {4'd10, 2'd0, 8'h05, 16'h0000, 1'b0, 16'h5555, 4'b0000, 8'h00, 1'b0, 1'b0}, // R10 line intact
      {4'd6,  2'd1, 8'h30, 16'hAAAA, 1'b1, 16'hAAAA, 4'b0110, 8'h00, 1'b0, 1'b0}, // R6 shared miss
      {4'd6,  2'd2, 8'h32, 16'h0000, 1'b0, 16'h1032, 4'b0000, 8'h00, 1'b1, 1'b1}, // R6 left SD
      {4'd6,  2'd1, 8'h09, 16'hCCCC, 1'b0, 16'hCCCC, 4'b0010, 8'h00, 1'b0, 1'b0}, // R6 private miss
      {4'd8,  2'd2, 8'h09, 16'h0000, 1'b0, 16'hCCCC, 4'b0000, 8'h00, 1'b1, 1'b1}, // R8 D -> SD
      {4'd7,  2'd0, 8'h28, 16'h0000, 1'b0, 16'h1028, 4'b1010, 8'h08, 1'b0, 1'b0}, // R7 SD victim
      {4'd7,  2'd0, 8'h09, 16'h0000, 1'b0, 16'hCCCC, 4'b0010, 8'h00, 1'b0, 1'b0}  // R7 data in memory
   };

   // Serves bus commands until the response pulse appears.
   task automatic serve(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic sh,
                        output logic [DW-1:0] got, output logic [3:0] mask,
                        output logic [AW-1:0] wb);
      bit seen = 0;
      mask = '0; wb = '0; got = '0;
      for (int c = 0; c < 40; c++) begin
         if (rsp_valid) begin got = rsp_rdata; seen = 1; break; end
         if (bus_cmd != 2'd0) begin
            mask[bus_cmd] = 1'b1;
            if (bus_cmd == 2'd1) begin
               chk(bus_addr == {a[AW-1:2], 2'b00}, "R2 read addr", 32'(bus_addr), 32'({a[AW-1:2], 2'b00}));
               for (int k = 0; k < NW; k++) bus_rdata[k*DW +: DW] = mem[bus_addr + AW'(k)];
            end else if (bus_cmd == 2'd2) begin
               chk(bus_addr == a && bus_wdata[DW-1:0] == d, "R5 update addr/word",
                   32'({bus_addr, bus_wdata[DW-1:0]}), 32'({a, d}));
            end else begin
               wb = bus_addr;
               for (int k = 0; k < NW; k++) mem[bus_addr + AW'(k)] = bus_wdata[k*DW +: DW];
            end
            bus_shared = sh;
            bus_done = 1'b1;
         end
         @(negedge clk);
         bus_done = 1'b0;
      end
      if (!seen) chk(1'b0, "R2 response timeout", 32'(0), 32'(1));
   endtask

   task automatic proc_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic sh, output logic [DW-1:0] got,
                          output logic [3:0] mask, output logic [AW-1:0] wb);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      serve(a, d, sh, got, mask, wb);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 32'(0), 32'(1));
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [DW-1:0] got;
      logic [3:0]    mask;
      logic [AW-1:0] wb;
      for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(16'h1000 + i);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state at the ports
      @(negedge clk);
      chk(req_ready == 1'b1 && bus_cmd == 2'd0 && rsp_valid == 1'b0, "R1 idle outputs",
          32'({req_ready, bus_cmd, rsp_valid}), 32'b1000);
      snp_valid = 1'b1; snp_upd = 1'b0; snp_addr = 8'h05;
      #1;
      chk(!snp_shared && !snp_supply, "R1 empty cache on snoop",
          32'({snp_shared, snp_supply}), 32'(0));
      @(negedge clk);
      snp_valid = 1'b0;

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = vec_t'(VECS[i]);
         if (v.op < 2) begin
            proc_op(v.op[0], v.addr, v.data, v.sh, got, mask, wb);
            if (got != v.exp_data) begin
               n_fail++; $display("FAIL R%0d vec %0d data: actual %0h expected %0h", v.req, i, got, v.exp_data);
            end
            if (mask != v.exp_mask) begin
               n_fail++; $display("FAIL R%0d vec %0d bus cmds: actual %b expected %b", v.req, i, mask, v.exp_mask);
            end
            if (v.exp_mask[3] && wb != v.exp_wb) begin
               n_fail++; $display("FAIL R%0d vec %0d wb addr: actual %0h expected %0h", v.req, i, wb, v.exp_wb);
            end
            n_tests += 2;
         end else begin
            @(negedge clk);
            snp_valid = 1'b1; snp_upd = v.op[0]; snp_addr = v.addr; snp_wdata = v.data;
            #1;
            n_tests++;
            if (snp_shared != v.exp_shared || snp_supply != v.exp_supply ||
                (v.exp_supply && snp_rdata[v.addr[1:0]*DW +: DW] != v.exp_data)) begin
               n_fail++;
               $display("FAIL R%0d vec %0d snoop: actual %b%b %0h expected %b%b %0h", v.req, i,
                        snp_shared, snp_supply, snp_rdata[v.addr[1:0]*DW +: DW],
                        v.exp_shared, v.exp_supply, v.exp_data);
            end
            @(negedge clk);
            snp_valid = 1'b0;
         end
      end

      // R12: command held while bus_done stays low (idx0 holds 0x30 Shared-Dirty)
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h40;
      @(negedge clk);
      req_valid = 1'b0;
      for (int c = 0; c < 3; c++) begin
         chk(bus_cmd == 2'd3 && bus_addr == 8'h30, "R12 write-back held",
             32'({bus_cmd, bus_addr}), 32'({2'd3, 8'h30}));
         @(negedge clk);
      end
      serve(8'h40, '0, 1'b0, got, mask, wb);
      chk(got == 16'h1040 && mask == 4'b1010, "R12 completes", 32'({got, mask}), 32'({16'h1040, 4'b1010}));

      // R11: snoop blocks the request, then it proceeds (R7 data written back)
      @(negedge clk);
      snp_valid = 1'b1; snp_upd = 1'b0; snp_addr = 8'hF0;
      req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h30;
      #1;
      chk(req_ready == 1'b0, "R11 ready low under snoop", 32'(req_ready), 32'(0));
      @(negedge clk);
      chk(bus_cmd == 2'd0 && !rsp_valid, "R11 request held off", 32'({bus_cmd, rsp_valid}), 32'(0));
      snp_valid = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      serve(8'h30, '0, 1'b0, got, mask, wb);
      chk(got == 16'hAAAA && mask == 4'b0010, "R11 request served after snoop",
          32'({got, mask}), 32'({16'hAAAA, 4'b0010}));

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule